// File: doc/BRIEF.md
# Authenticated-Encryption Tag Finaliser

This block closes an authenticated-encryption pass once every associated-data and message block has gone into the five-word, 128-bit-per-word cipher state. It does not hold that state. It watches a snapshot of the state held by an external state core, and it drives the core's update port. On a start pulse it packs the two byte lengths, converted to bit counts, into one 128-bit length word. It XORs that word with state word 3 to form a finalisation word. It then asks the core for seven consecutive updates, all with that same word. At the end it folds the five state words into the tag.

The caller chooses between two modes with the tag length input. A length of zero generates a tag: the whole 16-byte tag appears on the tag output. A non-zero length verifies a received tag: only the leading bytes of the computed tag are compared with the expected tag, and a single pass/fail bit is reported. The compare runs over all bytes in parallel with a mask, so the time to a result does not depend on which byte differs. A one-cycle done pulse marks the moment the results become valid, and the results then hold until the next operation.

Top module: `aead_tag_final`

## Requirements
- R1: The length word carries the associated-data length times 8 as a 64-bit little-endian value in bits [63:0] and the message length times 8 in bits [127:64].
- R2: The finalisation word equals state word 3 (bits [511:384] of the state input, with word k at bits [128k+127:128k]) XOR the length word, taken from the state present in the cycle that start is accepted.
- R3: After start, `upd_en` is high for exactly seven consecutive cycles, and `upd_word` holds the finalisation word unchanged throughout.
- R4: The tag is the XOR of the five state words as they stand after the seventh update.
- R5: With tag length 0, `tag_out` shows the full 16-byte tag and `tag_ok` is 0.
- R6: With tag length n from 1 to 16, computed tag bytes 0..n-1 (byte i at bits [8i+7:8i]) are compared with the same bytes of `exp_tag`. `tag_ok` is 1 only if all n match, bytes at or above n have no effect, and `tag_out` reads 0.
- R7: A tag length above 16 is treated as 16.
- R8: `done` is high for exactly one cycle, first sampled high nine cycles after the cycle in which start is applied, whatever the mismatch position. `tag_out` and `tag_ok` change only when `done` rises and hold otherwise.
- R9: A start pulse while an operation is in progress is ignored.
- R10: After reset, `done`, `upd_en`, `tag_ok` and `tag_out` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin finalisation (accepted when idle) |
| ad_len | input | LEN_W | Associated-data length in bytes |
| msg_len | input | LEN_W | Message length in bytes |
| exp_tag | input | 128 | Expected tag for verify mode |
| tag_len | input | TL_W | Bytes to compare; 0 selects generate mode |
| st_in | input | 640 | Current state from the core, word k at [128k+127:128k] |
| upd_en | output | 1 | Update request to the state core |
| upd_word | output | 128 | Word the core absorbs on each update |
| done | output | 1 | One-cycle completion pulse |
| tag_out | output | 128 | Full tag in generate mode, zero in verify mode |
| tag_ok | output | 1 | Verify result (1 = all compared bytes match) |

## Verification
The bench models the state core with its own simple update function. For every tag length from 0 to 16, and for one value above 16, it runs a fully matching expected tag and then one corrupted in each single byte position from 0 to 15. These runs separate a mask that is too wide or too narrow from a correct one, and show whether a mismatch beyond the compared bytes is ignored. The bench varies the associated-data and message lengths, including large values, and so catches swapped or misplaced length fields. It also measures the completion latency on every run, and sends an extra start during a busy operation to show that it is ignored.

// File: rtl/aead_fin_pkg.sv
package aead_fin_pkg;
  localparam int BLK_W  = 128;
  localparam int NWORDS = 5;
  localparam int NBYTES = BLK_W / 8;
  localparam int ST_W   = BLK_W * NWORDS;

  typedef logic [BLK_W-1:0] blk_t;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_RUN  = 2'd1,
    FS_FOLD = 2'd2
  } fin_state_e;
endpackage

// File: rtl/fin_lenword.sv
module fin_lenword
  import aead_fin_pkg::*;
#(
  parameter int LEN_W = 32
) (
  input  blk_t             st3,
  input  logic [LEN_W-1:0] ad_len,
  input  logic [LEN_W-1:0] msg_len,
  output blk_t             fin_word
);
  logic [63:0] ad_bits;
  logic [63:0] msg_bits;

  always_comb begin
    ad_bits  = 64'(ad_len) << 3;
    msg_bits = 64'(msg_len) << 3;
    fin_word = st3 ^ {msg_bits, ad_bits};
  end
endmodule

// File: rtl/fin_seq.sv
module fin_seq
  import aead_fin_pkg::*;
#(
  parameter int NUPD = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic upd_en,
  output logic fold
);
  localparam int CW = $clog2(NUPD + 1);

  fin_state_e     st_q;
  logic [CW-1:0]  cnt_q;

  assign load = (st_q == FS_IDLE) && start;
  assign fold = (st_q == FS_FOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= FS_IDLE;
      cnt_q  <= '0;
      upd_en <= 1'b0;
    end else begin
      case (st_q)
        FS_IDLE: if (start) begin
          st_q   <= FS_RUN;
          cnt_q  <= '0;
          upd_en <= 1'b1;
        end
        FS_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CW'(NUPD - 1)) begin
            upd_en <= 1'b0;
            st_q   <= FS_FOLD;
          end
        end
        default: st_q <= FS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fin_tagcmp.sv
module fin_tagcmp
  import aead_fin_pkg::*;
#(
  parameter int TL_W = 5
) (
  input  logic [ST_W-1:0] st_in,
  input  blk_t            exp_tag,
  input  logic [TL_W-1:0] tag_len,
  output blk_t            tag,
  output logic            match
);
  logic [NBYTES-1:0] byte_ok;
  logic [TL_W-1:0]   len_c;

  always_comb begin
    tag = '0;
    for (int w = 0; w < NWORDS; w++)
      tag = tag ^ st_in[w*BLK_W +: BLK_W];
    len_c = (tag_len > TL_W'(NBYTES)) ? TL_W'(NBYTES) : tag_len;
  end

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    assign byte_ok[i] = (TL_W'(i) >= len_c) ||
                        (tag[8*i +: 8] == exp_tag[8*i +: 8]);
  end

  assign match = &byte_ok;
endmodule

// File: rtl/aead_tag_final.sv
module aead_tag_final
  import aead_fin_pkg::*;
#(
  parameter int LEN_W = 32,
  parameter int NUPD  = 7,
  parameter int TL_W  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] ad_len,
  input  logic [LEN_W-1:0] msg_len,
  input  logic [127:0]     exp_tag,
  input  logic [TL_W-1:0]  tag_len,
  input  logic [639:0]     st_in,
  output logic             upd_en,
  output logic [127:0]     upd_word,
  output logic             done,
  output logic [127:0]     tag_out,
  output logic             tag_ok
);
  logic            load, fold, match;
  blk_t            fin_word, tag_c, exp_q;
  logic [TL_W-1:0] len_q;

  fin_lenword #(.LEN_W(LEN_W)) u_len (
    .st3     (st_in[3*BLK_W +: BLK_W]),
    .ad_len  (ad_len),
    .msg_len (msg_len),
    .fin_word(fin_word)
  );

  fin_seq #(.NUPD(NUPD)) u_seq (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .load  (load),
    .upd_en(upd_en),
    .fold  (fold)
  );

  fin_tagcmp #(.TL_W(TL_W)) u_cmp (
    .st_in  (st_in),
    .exp_tag(exp_q),
    .tag_len(len_q),
    .tag    (tag_c),
    .match  (match)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      upd_word <= '0;
      exp_q    <= '0;
      len_q    <= '0;
      done     <= 1'b0;
      tag_out  <= '0;
      tag_ok   <= 1'b0;
    end else begin
      done <= fold;
      if (load) begin
        upd_word <= fin_word;
        exp_q    <= exp_tag;
        len_q    <= tag_len;
      end
      if (fold) begin
        if (len_q == '0) begin
          tag_out <= tag_c;
          tag_ok  <= 1'b0;
        end else begin
          tag_out <= '0;
          tag_ok  <= match;
        end
      end
    end
  end
endmodule

// File: rtl/aead_tag_final_chk.sv
module aead_tag_final_chk #(
  parameter int NUPD = 7
) (
  input logic         clk,
  input logic         rst,
  input logic         upd_en,
  input logic [127:0] upd_word,
  input logic         done,
  input logic [127:0] tag_out,
  input logic         tag_ok
);
  logic [7:0] ucnt;

  always_ff @(posedge clk) begin
    if (rst || done) ucnt <= '0;
    else if (upd_en) ucnt <= ucnt + 1'b1;
  end

  // R3
  upd_count_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (ucnt == 8'(NUPD)));

  // R3
  upd_word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_en && $past(upd_en)) |-> $stable(upd_word));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(tag_out) && $stable(tag_ok)));

  // R6
  tag_hidden_chk: assert property (@(posedge clk) disable iff (rst)
    tag_ok |-> (tag_out == '0));

  // R8
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && upd_en));
endmodule

bind aead_tag_final aead_tag_final_chk #(.NUPD(NUPD)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .upd_en  (upd_en),
  .upd_word(upd_word),
  .done    (done),
  .tag_out (tag_out),
  .tag_ok  (tag_ok)
);

// File: tb/tb_aead_tag_final.sv
module tb_aead_tag_final;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [31:0]  ad_len = '0;
  logic [31:0]  msg_len = '0;
  logic [127:0] exp_tag = '0;
  logic [4:0]   tag_len = '0;
  logic [127:0] s [5];
  logic [639:0] st_in;
  logic         upd_en, done, tag_ok;
  logic [127:0] upd_word, tag_out;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  assign st_in = {s[4], s[3], s[2], s[1], s[0]};

  aead_tag_final dut (
    .clk(clk), .rst(rst), .start(start), .ad_len(ad_len), .msg_len(msg_len),
    .exp_tag(exp_tag), .tag_len(tag_len), .st_in(st_in), .upd_en(upd_en),
    .upd_word(upd_word), .done(done), .tag_out(tag_out), .tag_ok(tag_ok)
  );

  function automatic logic [127:0] mixf(logic [127:0] x);
    return {x[118:0], x[127:119]} ^ {x[63:0], x[127:64]} ^ 128'h3c;
  endfunction

  // state core model
  always @(posedge clk) begin
    if (upd_en) begin
      s[0] <= s[0] ^ upd_word ^ mixf(s[4]);
      s[4] <= s[4] ^ mixf(s[3]);
      s[3] <= s[3] ^ mixf(s[2]);
      s[2] <= s[2] ^ mixf(s[1]);
      s[1] <= s[1] ^ mixf(s[0]);
    end
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference tag from R1, R2, R3, R4
  function automatic logic [127:0] ref_tag(input logic [127:0] i0, i1, i2, i3, i4,
                                           input logic [31:0] al, ml);
    logic [127:0] v [5];
    logic [127:0] n [5];
    logic [127:0] t;
    v[0] = i0; v[1] = i1; v[2] = i2; v[3] = i3; v[4] = i4;
    t = v[3] ^ {64'(ml) * 64'd8, 64'(al) * 64'd8};
    for (int k = 0; k < 7; k++) begin
      n[0] = v[0] ^ t ^ mixf(v[4]);
      n[4] = v[4] ^ mixf(v[3]);
      n[3] = v[3] ^ mixf(v[2]);
      n[2] = v[2] ^ mixf(v[1]);
      n[1] = v[1] ^ mixf(v[0]);
      v = n;
    end
    return v[0] ^ v[1] ^ v[2] ^ v[3] ^ v[4];
  endfunction

  task automatic run_op(input int seed, input int tl, input int flip,
                        input logic [31:0] al, input logic [31:0] ml,
                        input bit extra_start);
    logic [127:0] tg, ex;
    int ncmp, lat, nupd;
    bit exp_ok;
    @(negedge clk);
    for (int k = 0; k < 5; k++)
      s[k] = {4{32'(seed * 32'h9e3779b1 + k * 32'h7f4a7c15 + 32'h1234)}} ^ 128'(k);
    tg = ref_tag(s[0], s[1], s[2], s[3], s[4], al, ml);
    ex = tg;
    if (flip >= 0) ex[8*flip +: 8] = ex[8*flip +: 8] ^ 8'h5a;
    ncmp = (tl > 16) ? 16 : tl;
    exp_ok = (tl != 0) && !(flip >= 0 && flip < ncmp);
    ad_len = al; msg_len = ml; exp_tag = ex; tag_len = 5'(tl);
    start = 1'b1;
    lat = 0; nupd = 0;
    for (int i = 1; i < 40; i++) begin
      @(negedge clk);
      start = 1'b0;
      if (extra_start && i == 3) begin
        start = 1'b1; ad_len = al ^ 32'h55; tag_len = 5'd0;
      end
      if (upd_en) nupd++;
      if (done) begin lat = i; break; end
    end
    start = 1'b0;
    // R8 latency, R3 update count
    chk(lat == 9, "R8 latency", 128'(lat), 128'd9);
    chk(nupd == 7, "R3 update count", 128'(nupd), 128'd7);
    if (tl == 0) begin
      // R5 / R4 / R1 / R2
      chk(tag_out == tg, "R5 R4 full tag", tag_out, tg);
      chk(tag_ok == 1'b0, "R5 tag_ok low", 128'(tag_ok), 128'd0);
    end else begin
      // R6 / R7
      chk(tag_ok == exp_ok, tl > 16 ? "R7 clamp compare" : "R6 compare",
          128'(tag_ok), 128'(exp_ok));
      chk(tag_out == '0, "R6 tag hidden", tag_out, 128'd0);
    end
    @(negedge clk);
    chk(done == 1'b0, "R8 done one cycle", 128'(done), 128'd0);
    // R8 hold; R9 ignored start
    chk(tag_out == ((tl == 0) ? tg : 128'd0) && tag_ok == exp_ok,
        extra_start ? "R9 busy start ignored" : "R8 hold",
        tag_out, (tl == 0) ? tg : 128'd0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    for (int k = 0; k < 5; k++) s[k] = '0;
    repeat (3) @(negedge clk);
    // R10
    chk(done == 0 && upd_en == 0 && tag_ok == 0 && tag_out == '0,
        "R10 reset state", {upd_en, done, tag_ok, tag_out[124:0]}, 128'd0);
    rst = 1'b0;
    // R1 length packing under several lengths
    run_op(1, 0, -1, 32'd0, 32'd0, 1'b0);
    run_op(2, 0, -1, 32'd13, 32'd0, 1'b0);
    run_op(3, 0, -1, 32'd0, 32'd77, 1'b0);
    run_op(4, 0, -1, 32'hffff_ffff, 32'h8000_0001, 1'b0);
    run_op(5, 0, -1, 32'h2000_0000, 32'd16, 1'b0);
    // R9
    run_op(6, 0, -1, 32'd40, 32'd64, 1'b1);
    run_op(7, 16, -1, 32'd40, 32'd64, 1'b1);
    // R6 / R5 sweep: every tag length, every single-byte flip
    for (int tl = 0; tl <= 16; tl++)
      for (int f = -1; f < 16; f++)
        run_op(100 + tl * 17 + f, tl, f, 32'(tl * 3 + 1), 32'(f + 20), 1'b0);
    // R7
    for (int f = -1; f < 16; f++)
      run_op(900 + f, 20, f, 32'd5, 32'd9, 1'b0);
    run_op(950, 31, 15, 32'd5, 32'd9, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule